// File: doc/BRIEF.md
# Receive Destination Address Filter

This block sits in the receive path of an Ethernet MAC and makes one accept-or-drop decision per incoming frame from its 48-bit destination address. The parser presents the address together with a CRC-32 of those six bytes, which is computed elsewhere, and pulses a valid strobe. One clock later the block returns a decision.

A frame is accepted in any of three cases:
- Promiscuous mode is on.
- An enabled exact-match entry equals all 48 address bits.
- The address is multicast, hashing is enabled, and the bit of a 64-bit hash table that the CRC selects is set.

Software programs the filter through a 16-bit register write port. After reset, entry 0 holds the broadcast address and is enabled. The station address is meant to go into entry 1. To rewrite an entry safely, software disables it, writes its three words, then enables it again.

The decision logic is a two-state machine:
- `ST_IDLE`: no decision is being presented.
- `ST_DECIDED`: a decision is on the outputs.

The transitions are named as follows:
- `GO_DECIDE` moves from `ST_IDLE` to `ST_DECIDED` when the strobe is seen.
- `STAY_DECIDED` keeps `ST_DECIDED` when strobes arrive back to back.
- `GO_IDLE` returns from `ST_DECIDED` to `ST_IDLE` when no strobe arrives.
- `STAY_IDLE` keeps `ST_IDLE` while no strobe arrives.

Top module: `da_accept_filter`

## Requirements
- R1: After reset `dec_valid` and `dec_accept` are low. The control word is 0x0004, which enables entry 0 only. Entry 0 holds 0xFFFF in every word. All other entries and all hash words are zero.
- R2: `dec_valid` is high in the cycle after each cycle in which `da_valid` is high, and low otherwise. Back-to-back strobes give back-to-back decisions.
- R3: When control bit 0 (promiscuous) is set, every address is accepted.
- R4: Entry e occupies register addresses 0x08+4e+w, where w=0 is the low word, w=1 the middle word and w=2 the high word.
  - The address byte k is `da_in[8k+7:8k]`, and byte 0 is first on the wire.
  - The low word holds byte1:byte0, the middle word byte3:byte2, and the high word byte5:byte4.
  - An enabled entry whose 48 bits all equal the address causes acceptance. A single differing bit prevents that entry from matching.
- R5: An entry whose enable bit (control bit 2+e) is clear never causes acceptance.
- R6: With the reset configuration, the broadcast address FF:FF:FF:FF:FF:FF is accepted.
- R7: The hash index is `crc_in[28:23]`.
  - Index bits [5:4] select the hash word at register address 0x01+idx[5:4].
  - Index bits [3:0] select the bit within that word.
  - A multicast address (`da_in[0]`=1) whose selected bit is set is accepted when control bit 1 (hash enable) is set.
- R8: A hash hit is ignored when the address is unicast or when hash enable is clear.
- R9: With all four hash words at 0xFFFF and hash enable set, every multicast address is accepted.
- R10: A register write in the same cycle as a strobe does not affect that decision. It applies from the next address onward.
- R11: Any address that meets none of the acceptance conditions is dropped, that is, `dec_valid`=1 and `dec_accept`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| da_valid | input | 1 | Destination address strobe |
| da_in | input | 48 | Destination address, byte k at bits 8k+7:8k |
| crc_in | input | 32 | CRC-32 of the six address bytes |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 5 | Register address |
| wr_data | input | 16 | Register write data |
| dec_valid | output | 1 | Decision present |
| dec_accept | output | 1 | Accept (1) or drop (0) |

## Verification
The bench tries the following address patterns, and each one separates a different acceptance path:
- The broadcast address, a programmed station address, and that station address with one bit flipped tell the exact-match path apart from a near miss.
- Entry enable and disable separates stored contents from the enable gating.
- Multicast and unicast addresses with CRC values that land on a set bit and on a neighbouring clear bit separate hash indexing from the multicast and hash-enable gating.
- A full hash table and promiscuous mode are each tried on otherwise rejected addresses.
- A control write issued in the same cycle as a strobe shows whether the new setting leaks into the pending decision.

// File: rtl/da_filter_pkg.sv
package da_filter_pkg;
    localparam int ADDR_BITS  = 48;
    localparam int WORD_BITS  = 16;
    localparam int HASH_BITS  = 64;
    localparam int HIDX_LSB   = 23;
    localparam int HIDX_W     = $clog2(HASH_BITS);
    localparam int CTL_PROMISC = 0;
    localparam int CTL_HASHEN  = 1;
    localparam int CTL_ENT_LSB = 2;
    localparam int REG_HASH0   = 1;
    localparam int REG_ENT0    = 8;
    localparam int ENT_STRIDE  = 4;
    localparam int ENT_WORDS   = ADDR_BITS / WORD_BITS;

    typedef enum logic {
        ST_IDLE    = 1'b0,
        ST_DECIDED = 1'b1
    } dec_state_e;
endpackage

// File: rtl/da_cfg_regs.sv
module da_cfg_regs
    import da_filter_pkg::*;
#(
    parameter int NUM_EXACT = 4,
    parameter int ADDR_W    = 5
) (
    input  logic                                  clk,
    input  logic                                  rst,
    input  logic                                  wr_en,
    input  logic [ADDR_W-1:0]                     wr_addr,
    input  logic [WORD_BITS-1:0]                  wr_data,
    output logic                                  promisc,
    output logic                                  hash_en,
    output logic [NUM_EXACT-1:0]                  ent_en,
    output logic [HASH_BITS-1:0]                  hash_tbl,
    output logic [NUM_EXACT-1:0][ADDR_BITS-1:0]   ent_addr
);
    localparam int HWORDS = HASH_BITS / WORD_BITS;

    logic [WORD_BITS-1:0] ctl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= WORD_BITS'(1 << CTL_ENT_LSB);
        end else if (wr_en && wr_addr == '0) begin
            ctl_q <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hash_tbl <= '0;
        end else if (wr_en) begin
            for (int h = 0; h < HWORDS; h++) begin
                if (wr_addr == ADDR_W'(REG_HASH0 + h))
                    hash_tbl[h*WORD_BITS +: WORD_BITS] <= wr_data;
            end
        end
    end

    for (genvar e = 0; e < NUM_EXACT; e++) begin : g_ent
        always_ff @(posedge clk) begin
            if (rst) begin
                ent_addr[e] <= (e == 0) ? '1 : '0;
            end else if (wr_en) begin
                for (int w = 0; w < ENT_WORDS; w++) begin
                    if (wr_addr == ADDR_W'(REG_ENT0 + ENT_STRIDE*e + w))
                        ent_addr[e][w*WORD_BITS +: WORD_BITS] <= wr_data;
                end
            end
        end
    end

    assign promisc = ctl_q[CTL_PROMISC];
    assign hash_en = ctl_q[CTL_HASHEN];
    assign ent_en  = ctl_q[CTL_ENT_LSB +: NUM_EXACT];

    logic unused_ctl;
    assign unused_ctl = ^ctl_q[WORD_BITS-1:CTL_ENT_LSB+NUM_EXACT];
endmodule

// File: rtl/da_exact_match.sv
module da_exact_match
    import da_filter_pkg::*;
#(
    parameter int NUM_EXACT = 4
) (
    input  logic [ADDR_BITS-1:0]                 da,
    input  logic [NUM_EXACT-1:0]                 ent_en,
    input  logic [NUM_EXACT-1:0][ADDR_BITS-1:0]  ent_addr,
    output logic [NUM_EXACT-1:0]                 hit
);
    for (genvar e = 0; e < NUM_EXACT; e++) begin : g_cmp
        assign hit[e] = ent_en[e] && (ent_addr[e] == da);
    end
endmodule

// File: rtl/da_hash_lookup.sv
module da_hash_lookup
    import da_filter_pkg::*;
(
    input  logic [HIDX_W-1:0]    hidx,
    input  logic                 mcast,
    input  logic                 hash_en,
    input  logic [HASH_BITS-1:0] hash_tbl,
    output logic                 hit
);
    assign hit = mcast && hash_en && hash_tbl[hidx];
endmodule

// File: rtl/da_accept_filter.sv
module da_accept_filter
    import da_filter_pkg::*;
#(
    parameter int NUM_EXACT = 4,
    localparam int ADDR_W = $clog2(REG_ENT0 + ENT_STRIDE*NUM_EXACT)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  da_valid,
    input  logic [47:0]           da_in,
    input  logic [31:0]           crc_in,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [15:0]           wr_data,
    output logic                  dec_valid,
    output logic                  dec_accept
);
    logic                                 promisc, hash_en, hash_hit;
    logic [NUM_EXACT-1:0]                 ent_en, exact_hit;
    logic [HASH_BITS-1:0]                 hash_tbl;
    logic [NUM_EXACT-1:0][ADDR_BITS-1:0]  ent_addr;
    logic                                 accept_now, acc_q;
    dec_state_e                           state_q, state_d;

    da_cfg_regs #(.NUM_EXACT(NUM_EXACT), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .promisc(promisc), .hash_en(hash_en),
        .ent_en(ent_en), .hash_tbl(hash_tbl), .ent_addr(ent_addr)
    );

    da_exact_match #(.NUM_EXACT(NUM_EXACT)) u_exact (
        .da(da_in), .ent_en(ent_en), .ent_addr(ent_addr), .hit(exact_hit)
    );

    da_hash_lookup u_hash (
        .hidx(crc_in[HIDX_LSB +: HIDX_W]), .mcast(da_in[0]),
        .hash_en(hash_en), .hash_tbl(hash_tbl), .hit(hash_hit)
    );

    logic unused_crc;
    assign unused_crc = ^{crc_in[31:HIDX_LSB+HIDX_W], crc_in[HIDX_LSB-1:0]};

    assign accept_now = promisc || (|exact_hit) || hash_hit;

    // State register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // Next state: GO_DECIDE / STAY_DECIDED on a strobe, GO_IDLE / STAY_IDLE otherwise
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    state_d = da_valid ? ST_DECIDED : ST_IDLE;
            ST_DECIDED: state_d = da_valid ? ST_DECIDED : ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // Decision captured with the configuration present at the strobe
    always_ff @(posedge clk) begin
        if (rst)           acc_q <= 1'b0;
        else if (da_valid) acc_q <= accept_now;
        else               acc_q <= 1'b0;
    end

    // Outputs
    always_comb begin
        dec_valid  = (state_q == ST_DECIDED);
        dec_accept = dec_valid && acc_q;
    end
endmodule

// File: rtl/da_filter_checker.sv
module da_filter_checker #(
    parameter int NUM_EXACT = 4
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 da_valid,
    input logic                 da_mcast,
    input logic                 promisc,
    input logic [NUM_EXACT-1:0] exact_hit,
    input logic                 dec_valid,
    input logic                 dec_accept
);
    assert_strobe_gives_decision_R2: assert property (@(posedge clk) disable iff (rst)
        da_valid |=> dec_valid);

    assert_no_strobe_no_decision_R2: assert property (@(posedge clk) disable iff (rst)
        !da_valid |=> !dec_valid);

    assert_promisc_accepts_R3: assert property (@(posedge clk) disable iff (rst)
        (da_valid && promisc) |=> dec_accept);

    assert_exact_hit_accepts_R4: assert property (@(posedge clk) disable iff (rst)
        (da_valid && (exact_hit != '0)) |=> dec_accept);

    assert_unicast_no_hash_R8: assert property (@(posedge clk) disable iff (rst)
        (da_valid && !da_mcast && !promisc && exact_hit == '0) |=> (dec_valid && !dec_accept));
endmodule

bind da_accept_filter da_filter_checker #(.NUM_EXACT(NUM_EXACT)) u_chk (
    .clk(clk), .rst(rst), .da_valid(da_valid), .da_mcast(da_in[0]),
    .promisc(promisc), .exact_hit(exact_hit),
    .dec_valid(dec_valid), .dec_accept(dec_accept)
);

// File: tb/test_da_accept_filter.sv
`timescale 1ns/100ps
module test_da_accept_filter;
    localparam int NE = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        da_valid = 1'b0;
    logic [47:0] da_in = '0;
    logic [31:0] crc_in = '0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        dec_valid, dec_accept;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // behavioural model state
    logic [15:0] m_ctl;
    logic [15:0] m_hash [4];
    logic [15:0] m_ent  [NE][3];

    always #2.5 clk = ~clk;

    da_accept_filter #(.NUM_EXACT(NE)) i_da_accept_filter (
        .clk(clk), .rst(rst), .da_valid(da_valid), .da_in(da_in), .crc_in(crc_in),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .dec_valid(dec_valid), .dec_accept(dec_accept)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit model_accept(input logic [47:0] da, input logic [31:0] crc);
        int idx;
        bit acc;
        acc = m_ctl[0];
        for (int e = 0; e < NE; e++) begin
            bit same;
            same = 1;
            for (int b = 0; b < 6; b++) begin
                logic [7:0] stored;
                stored = (b % 2 == 0) ? m_ent[e][b/2][7:0] : m_ent[e][b/2][15:8];
                if (stored != da[8*b +: 8]) same = 0;
            end
            if (m_ctl[2+e] && same) acc = 1;
        end
        idx = int'(crc[28:23]);
        if (da[0] && m_ctl[1] && m_hash[idx/16][idx%16]) acc = 1;
        return acc;
    endfunction

    task automatic model_write(input logic [4:0] a, input logic [15:0] d);
        if (a == 0) m_ctl = d;
        else if (a >= 1 && a <= 4) m_hash[a-1] = d;
        else if (a >= 8 && a < 8 + 4*NE && (a - 8) % 4 != 3) m_ent[(a-8)/4][(a-8)%4] = d;
    endtask

    // one clock: drive at negedge, compare at the following negedge
    task automatic step(input bit v, input logic [47:0] da, input logic [31:0] crc,
                        input bit w, input logic [4:0] a, input logic [15:0] d,
                        input string req);
        bit exp_acc;
        da_valid = v; da_in = da; crc_in = crc;
        wr_en = w; wr_addr = a; wr_data = d;
        exp_acc = v ? model_accept(da, crc) : 1'b0;
        @(posedge clk);
        if (w) model_write(a, d);
        @(negedge clk);
        check(dec_valid == v, {req, " valid"}, int'(dec_valid), int'(v));
        check(dec_accept == exp_acc, {req, " accept"}, int'(dec_accept), int'(exp_acc));
        da_valid = 0; wr_en = 0;
    endtask

    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        step(0, '0, '0, 1, a, d, "R2 idle during write");
    endtask

    localparam logic [47:0] STATION = {8'h09, 8'h13, 8'h00, 8'h43, 8'h07, 8'h00};
    localparam logic [47:0] MCAST   = 48'h0000_5E00_0001;

    initial begin
        m_ctl = 16'h0004;
        for (int h = 0; h < 4; h++) m_hash[h] = '0;
        for (int e = 0; e < NE; e++)
            for (int w = 0; w < 3; w++) m_ent[e][w] = (e == 0) ? 16'hFFFF : 16'h0000;

        repeat (3) @(negedge clk);
        check(dec_valid == 0 && dec_accept == 0, "R1 outputs in reset", int'(dec_valid), 0);
        rst = 0;
        step(0, '0, '0, 0, '0, '0, "R1 idle after reset");

        step(1, '1, 32'h1234_5678, 0, '0, '0, "R6 broadcast");
        step(1, 48'h6655_4433_2211, 32'h0, 0, '0, '0, "R11 unicast drop");
        step(1, '1, 32'h0, 0, '0, '0, "R2 back-to-back");

        // station address into entry 1: low=byte1:byte0
        wr(5'h0C, 16'h0700);
        wr(5'h0D, 16'h0043);
        wr(5'h0E, 16'h0913);
        step(1, STATION, '0, 0, '0, '0, "R5 entry disabled");
        wr(5'h00, 16'h000C);
        step(1, STATION, '0, 0, '0, '0, "R4 station match");
        step(1, STATION ^ 48'h8000_0000_0000, '0, 0, '0, '0, "R4 one bit differs");
        wr(5'h00, 16'h0008);
        step(1, '1, '0, 0, '0, '0, "R5 broadcast entry disabled");
        step(1, STATION, '0, 0, '0, '0, "R4 station still matches");

        // hash: word 2 bit 5 -> index 37
        wr(5'h03, 16'h0020);
        step(1, MCAST, 32'(37) << 23, 0, '0, '0, "R8 hash enable clear");
        wr(5'h00, 16'h000A);
        step(1, MCAST, 32'(37) << 23, 0, '0, '0, "R7 hash hit");
        step(1, MCAST, (32'(37) << 23) | 32'hE000_0001, 0, '0, '0, "R7 other crc bits ignored");
        step(1, MCAST, 32'(36) << 23, 0, '0, '0, "R7 neighbour bit clear");
        step(1, MCAST & ~48'h1, 32'(37) << 23, 0, '0, '0, "R8 unicast ignores hash");

        for (int h = 1; h <= 4; h++) wr(5'(h), 16'hFFFF);
        for (int k = 0; k < 64; k += 9)
            step(1, MCAST ^ 48'(k << 8), 32'(k) << 23, 0, '0, '0, "R9 all-ones hash");

        wr(5'h00, 16'h0001);
        step(1, 48'hA0B0_C0D0_E0F0, 32'h0, 0, '0, '0, "R3 promiscuous");
        step(1, 48'h1234_5678_9ABC, 32'h0, 1, 5'h00, 16'h0000, "R10 write with strobe");
        step(1, 48'h1234_5678_9ABC, 32'h0, 0, '0, '0, "R10 next address sees write");
        step(0, '0, '0, 0, '0, '0, "R2 gap");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #20000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule